// File: doc/BRIEF.md
# Daisy-Chain Bus Grant Requester

This block is the bus requester of one master on a shared bus where the central arbiter hands out the bus by driving a grant down a chain of slots. When the local master wants the bus, the block pulls its request line low. When a grant reaches the slot, the block either keeps it and tells the local master it now owns the bus, or passes it on through its own grant output to the next slot down the chain.

The incoming grant has no timing relation to the local clock or to the local request. The two can change at the same instant, so the flip-flop that first samples the pass-or-keep choice will often see its setup time violated. The block therefore treats that first sample as untrusted. The choice goes through a second register stage before the control logic acts on it, and the grant output is only ever driven from the state that settled value produces. With a clock period of roughly 50 ns, a first stage that goes metastable and settles within 20 to 45 ns has resolved before the second stage samples it.

Once the block starts forwarding, it keeps forwarding until the incoming grant goes away. A request that arrives in that window waits for the next grant. Once the block keeps a grant, it holds ownership until the local master pulses release. It then ignores the chain until the incoming grant has gone inactive.

Top module: `breq_daisy_requester`

## Requirements
- R1: A synchronous active-high reset, seen at a clock edge, leaves bus_req_n high, grant_out_n high and owned_o low from the next edge on. All chain lines are active-low: 0 means asserted.
- R2: While the block is neither owning the bus nor waiting after a release, want_bus_i high at a clock edge drives bus_req_n low from that edge, and it stays low until a grant is kept.
- R3: A grant (grant_in_n low) that is captured while no request is pending is forwarded. grant_out_n goes low at the third clock edge after grant_in_n falls and stays high at the first and second edges.
- R4: A grant that is captured while a request is pending is kept. owned_o rises at the third clock edge after grant_in_n falls, and grant_out_n stays high throughout.
- R5: grant_out_n only falls after the second decision stage has held a forward decision, which is a captured grant with no pending request, in the preceding cycle.
- R6: Once forwarding, grant_out_n stays low while grant_in_n stays low, even if want_bus_i rises in the meantime. It returns high at the third edge after grant_in_n rises. A request raised during forwarding is served by the next grant.
- R7: While owned_o is high, bus_req_n is high, and owned_o stays high until release_i is seen high at a clock edge.
- R8: release_i seen high while owning clears owned_o at that edge. After that, until the second stage has seen grant_in_n inactive, want_bus_i is ignored and no grant is forwarded: bus_req_n and grant_out_n stay high.
- R9: release_i seen high while not owning has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| want_bus_i | input | 1 | Local master wants the bus, active high |
| release_i | input | 1 | Single-cycle pulse: local master gives the bus back |
| grant_in_n | input | 1 | Grant arriving from the previous slot, active low, asynchronous |
| bus_req_n | output | 1 | Bus request to the arbiter, active low |
| grant_out_n | output | 1 | Grant passed to the next slot, active low |
| owned_o | output | 1 | Local master owns the bus, active high |

## Verification
The bench changes the local request right around the arrival of a grant. A design that decided from the live request instead of the captured one would both keep and forward, which is the double-ownership hazard. It times the grant output edge by edge, so a design that drove the chain from the first capture stage, one edge early, is caught. It raises a request in the middle of forwarding, where a design that cut the grant off would strand the slot downstream. It also holds want_bus_i high during the post-release wait, so that a design which re-requested or forwarded before the incoming grant cleared would show up on bus_req_n or grant_out_n. Random chains of grants, requests and releases are then compared cycle by cycle against a bench-side model.

// File: rtl/breq_pkg.sv
package breq_pkg;

    // Control states of the requester
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // neither forwarding nor owning
        ST_FWD  = 2'd1,   // passing the grant down the chain
        ST_OWN  = 2'd2,   // grant kept, local master owns the bus
        ST_WAIT = 2'd3    // released, waiting for grant-in to clear
    } breq_state_e;

    // Pass-or-keep decision travelling through the capture stages
    typedef struct packed {
        logic seen;   // grant-in was asserted when sampled
        logic keep;   // a request was pending when sampled
    } breq_dec_t;

    // Registered control state
    typedef struct packed {
        breq_state_e state;
        logic        pend;
    } breq_ctrl_t;

endpackage

// File: rtl/breq_capture.sv
module breq_capture
    import breq_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      grant_in_n,
    input  logic      pend_i,
    output breq_dec_t dec_o
);

    localparam int LAST = STAGES - 1;

    breq_dec_t st_d [STAGES];
    breq_dec_t st_q [STAGES];

    // Stage 0 samples the asynchronous grant together with the request
    // state; every later stage only re-times the stage before it.
    always_comb begin
        st_d[0].seen = ~grant_in_n;
        st_d[0].keep = pend_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) begin
                st_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                st_q[i] <= st_d[i];
            end
        end
    end

    // Only the settled final stage leaves this module
    assign dec_o = st_q[LAST];

endmodule

// File: rtl/breq_ctrl.sv
module breq_ctrl
    import breq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  breq_dec_t dec_i,
    input  logic      want_bus_i,
    input  logic      release_i,
    output logic      pend_o,
    output logic      bus_req_n,
    output logic      grant_out_n,
    output logic      owned_o
);

    breq_ctrl_t c_d;
    breq_ctrl_t c_q;

    always_comb begin
        c_d = c_q;
        unique case (c_q.state)
            ST_IDLE: begin
                c_d.pend = c_q.pend | want_bus_i;
                if (dec_i.seen) begin
                    if (dec_i.keep) begin
                        c_d.state = ST_OWN;
                        c_d.pend  = 1'b0;
                    end else begin
                        c_d.state = ST_FWD;
                    end
                end
            end
            ST_FWD: begin
                // a late request is remembered but the grant keeps flowing
                c_d.pend = c_q.pend | want_bus_i;
                if (!dec_i.seen) begin
                    c_d.state = ST_IDLE;
                end
            end
            ST_OWN: begin
                c_d.pend = 1'b0;
                if (release_i) begin
                    c_d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                c_d.pend = 1'b0;
                if (!dec_i.seen) begin
                    c_d.state = ST_IDLE;
                end
            end
            default: begin
                c_d.state = ST_IDLE;
                c_d.pend  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q.state <= ST_IDLE;
            c_q.pend  <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign pend_o      = c_q.pend;
    assign bus_req_n   = ~c_q.pend;
    assign grant_out_n = ~(c_q.state == ST_FWD);
    assign owned_o     = (c_q.state == ST_OWN);

endmodule

// File: rtl/breq_daisy_requester.sv
module breq_daisy_requester
    import breq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic want_bus_i,
    input  logic release_i,
    input  logic grant_in_n,
    output logic bus_req_n,
    output logic grant_out_n,
    output logic owned_o
);

    breq_dec_t dec_s2;
    logic      pend;

    breq_capture #(
        .STAGES (SYNC_STAGES)
    ) capture_i (
        .clk        (clk),
        .rst        (rst),
        .grant_in_n (grant_in_n),
        .pend_i     (pend),
        .dec_o      (dec_s2)
    );

    breq_ctrl ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .dec_i       (dec_s2),
        .want_bus_i  (want_bus_i),
        .release_i   (release_i),
        .pend_o      (pend),
        .bus_req_n   (bus_req_n),
        .grant_out_n (grant_out_n),
        .owned_o     (owned_o)
    );

endmodule

// File: rtl/breq_checker.sv
module breq_checker (
    input logic clk,
    input logic rst,
    input logic release_i,
    input logic bus_req_n,
    input logic grant_out_n,
    input logic owned_o,
    input logic s2_seen,
    input logic s2_keep
);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (bus_req_n && grant_out_n && !owned_o));

    p_keep_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(owned_o) |-> grant_out_n);

    p_gout_settled_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(grant_out_n) |-> $past(s2_seen && !s2_keep));

    p_fwd_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (!grant_out_n && s2_seen) |=> !grant_out_n);

    p_owned_no_req_r7: assert property (@(posedge clk) disable iff (rst)
        owned_o |-> bus_req_n);

    p_owned_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (owned_o && !release_i) |=> owned_o);

    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        (owned_o && release_i) |=> (!owned_o && bus_req_n && grant_out_n));

endmodule

bind breq_daisy_requester breq_checker chk_i (
    .clk         (clk),
    .rst         (rst),
    .release_i   (release_i),
    .bus_req_n   (bus_req_n),
    .grant_out_n (grant_out_n),
    .owned_o     (owned_o),
    .s2_seen     (dec_s2.seen),
    .s2_keep     (dec_s2.keep)
);

// File: tb/breq_daisy_requester_tb.sv
module breq_daisy_requester_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic want_bus_i = 1'b0;
    logic release_i = 1'b0;
    logic grant_in_n = 1'b1;
    logic bus_req_n;
    logic grant_out_n;
    logic owned_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    breq_daisy_requester dut_i (
        .clk         (clk),
        .rst         (rst),
        .want_bus_i  (want_bus_i),
        .release_i   (release_i),
        .grant_in_n  (grant_in_n),
        .bus_req_n   (bus_req_n),
        .grant_out_n (grant_out_n),
        .owned_o     (owned_o)
    );

    // Bench-side model built from the requirements (0 idle,1 fwd,2 own,3 wait)
    bit m_s1_seen, m_s1_keep, m_s2_seen, m_s2_keep, m_pend;
    int m_state;

    function automatic bit exp_req_n();  return !m_pend;       endfunction
    function automatic bit exp_gout_n(); return m_state != 1;  endfunction
    function automatic bit exp_owned();  return m_state == 2;  endfunction

    task automatic model_edge();
        bit ns1s, ns1k, npend;
        int nst;
        ns1s = !grant_in_n;
        ns1k = m_pend;
        npend = m_pend;
        nst = m_state;
        if (rst) begin
            ns1s = 0; ns1k = 0; npend = 0; nst = 0;
            m_s2_seen = 0; m_s2_keep = 0;
        end else begin
            case (m_state)
                0: begin
                    npend = m_pend | want_bus_i;
                    if (m_s2_seen) begin
                        if (m_s2_keep) begin nst = 2; npend = 0; end
                        else nst = 1;
                    end
                end
                1: begin
                    npend = m_pend | want_bus_i;
                    if (!m_s2_seen) nst = 0;
                end
                2: begin npend = 0; if (release_i) nst = 3; end
                default: begin npend = 0; if (!m_s2_seen) nst = 0; end
            endcase
            m_s2_seen = m_s1_seen;
            m_s2_keep = m_s1_keep;
        end
        m_s1_seen = ns1s;
        m_s1_keep = ns1k;
        m_pend = npend;
        m_state = nst;
    endtask

    task automatic chk(bit ok, string tag, int act, int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic cmp_model(string tag);
        chk(bus_req_n == exp_req_n(), {tag, " bus_req_n"}, bus_req_n, exp_req_n());
        chk(grant_out_n == exp_gout_n(), {tag, " grant_out_n"}, grant_out_n, exp_gout_n());
        chk(owned_o == exp_owned(), {tag, " owned_o"}, owned_o, exp_owned());
    endtask

    // one clock: model follows the edge, outputs sampled at the falling edge
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20250611));
        m_state = 0;
        @(negedge clk);
        repeat (3) step();
        rst = 1'b0;
        // R1: reset values on the active-low chain lines
        chk(bus_req_n == 1'b1, "R1 bus_req_n", bus_req_n, 1);
        chk(grant_out_n == 1'b1, "R1 grant_out_n", grant_out_n, 1);
        chk(owned_o == 1'b0, "R1 owned_o", owned_o, 0);

        // R3/R5: grant with no request is forwarded on the third edge only
        grant_in_n = 1'b0;
        step(); chk(grant_out_n == 1'b1, "R5 edge1", grant_out_n, 1);
        step(); chk(grant_out_n == 1'b1, "R5 edge2", grant_out_n, 1);
        step(); chk(grant_out_n == 1'b0, "R3 edge3", grant_out_n, 0);
        cmp_model("R3");

        // R2/R6: late request during forwarding does not stop the grant
        want_bus_i = 1'b1;
        step();
        chk(bus_req_n == 1'b0, "R2 req", bus_req_n, 0);
        chk(grant_out_n == 1'b0, "R6 still fwd", grant_out_n, 0);
        repeat (4) begin step(); chk(grant_out_n == 1'b0, "R6 hold", grant_out_n, 0); end
        grant_in_n = 1'b1;
        step(); step(); chk(grant_out_n == 1'b0, "R6 edge2", grant_out_n, 0);
        step(); chk(grant_out_n == 1'b1, "R6 edge3", grant_out_n, 1);
        chk(owned_o == 1'b0, "R6 no own", owned_o, 0);

        // R4/R7: next grant is kept
        want_bus_i = 1'b0;
        step();
        grant_in_n = 1'b0;
        step(); step(); chk(owned_o == 1'b0, "R4 edge2", owned_o, 0);
        step();
        chk(owned_o == 1'b1, "R4 owned", owned_o, 1);
        chk(grant_out_n == 1'b1, "R4 no fwd", grant_out_n, 1);
        chk(bus_req_n == 1'b1, "R7 req dropped", bus_req_n, 1);
        repeat (5) begin step(); chk(owned_o == 1'b1, "R7 hold", owned_o, 1); end

        // R8: release, then nothing until grant-in clears
        release_i = 1'b1;
        step();
        release_i = 1'b0;
        chk(owned_o == 1'b0, "R8 released", owned_o, 0);
        want_bus_i = 1'b1;
        repeat (4) begin
            step();
            chk(bus_req_n == 1'b1, "R8 no req", bus_req_n, 1);
            chk(grant_out_n == 1'b1, "R8 no fwd", grant_out_n, 1);
        end
        grant_in_n = 1'b1;
        step(); step(); step();
        chk(bus_req_n == 1'b1, "R8 still waiting", bus_req_n, 1);
        step();
        chk(bus_req_n == 1'b0, "R8 req again", bus_req_n, 0);

        // R9: release while not owning changes nothing
        want_bus_i = 1'b0;
        release_i = 1'b1;
        step();
        release_i = 1'b0;
        chk(bus_req_n == 1'b0, "R9 req kept", bus_req_n, 0);
        chk(owned_o == 1'b0, "R9 owned", owned_o, 0);
        chk(grant_out_n == 1'b1, "R9 gout", grant_out_n, 1);
        grant_in_n = 1'b0;
        step(); step(); step();
        chk(owned_o == 1'b1, "R9 keep after ignored release", owned_o, 1);
        cmp_model("R9");

        // Random mix: R2 R3 R4 R6 R7 R8 against the model
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(5) == 0) grant_in_n = ~grant_in_n;
            if ($urandom_range(3) == 0) want_bus_i = ~want_bus_i;
            release_i = ($urandom_range(9) == 0);
            step();
            cmp_model("R2/R3/R4/R6/R7/R8 random");
        end

        // R1: reset in the middle of traffic
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk(bus_req_n == 1'b1, "R1 mid req", bus_req_n, 1);
        chk(grant_out_n == 1'b1, "R1 mid gout", grant_out_n, 1);
        chk(owned_o == 1'b0, "R1 mid own", owned_o, 0);
        finish_run();
    end

endmodule